// File: doc/BRIEF.md
# Hierarchical state machine with history

This controller runs a two-level state machine. At the outer level it is either idle or inside a super-state. Inside the super-state exactly one of five leaf states (A, B, C, D, E) is active. An advance event moves the leaf forward in a ring. A plain entry always lands on a fixed default leaf. A resume entry returns to the leaf that was active when the super-state was last left. One abort event leaves the super-state from whichever leaf is active. Leaf C is timed: event `a` moves it on to D, and if 20 millisecond ticks arrive first, an internal timeout moves it back to A.

Every input is a one-cycle pulse. Pulses are caught in an event register and acted on in the following step, after which they are gone. The timeout is raised the same way, as an internal event. All next values are worked out from the current values and then committed together on one edge.

Top module: `hsm_ctrl`

## Requirements
- R1: After synchronous reset the block is idle, `leaf_onehot` is 0, `in_super` is 0, and the stored history is empty, so a first resume lands on A.
- R2: A pulse on an event input changes the outputs at the second rising edge after it is sampled, never at the first. A single pulse acts exactly once.
- R3: In idle, `ev_enter` enters leaf A (bit 0). While inside the super-state, `ev_enter` and `ev_resume` have no effect.
- R4: `ev_step` advances A→B→C→D→E→A. Leaf i is shown on `leaf_onehot[i]`, with A=0, B=1, C=2, D=3, E=4.
- R5: `ev_abort` returns the block to idle from any leaf. In idle, `ev_abort` has no effect and does not change the stored history.
- R6: `ev_resume` in idle re-enters the leaf that was active at the most recent abort.
- R7: `ev_resume` with no prior exit since reset enters A.
- R8: When `ev_abort` and `ev_step` arrive in the same step, the abort wins and the block goes idle. The history then holds the leaf that was active before that step.
- R9: When `ev_enter` and `ev_resume` arrive together in idle, the resume wins.
- R10: In leaf C, `ev_a` moves to D. In any other leaf, `ev_a` has no effect.
- R11: In leaf C, the 20th `ms_tick` with no `ev_a` moves the block to A. After 19 ticks it is still in C.
- R12: The tick count restarts on every entry into C. Ticks counted during an earlier visit do not carry over.
- R13: At most one bit of `leaf_onehot` is set, and `in_super` is 1 exactly when one bit is set. `ev_step` and `ms_tick` have no effect in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_enter | input | 1 | Default-entry event pulse |
| ev_resume | input | 1 | History-entry event pulse |
| ev_abort | input | 1 | Exception event pulse, leaves the super-state |
| ev_step | input | 1 | Advance event pulse |
| ev_a | input | 1 | Event `a`, consumed in leaf C |
| ms_tick | input | 1 | One pulse per millisecond |
| leaf_onehot | output | 5 | One-hot active leaf, all zero in idle |
| in_super | output | 1 | High while the super-state is active |

## Verification
The hardest condition to reach from the ports is a timeout that must count only ticks from the current visit to C. To build it, the stimulus spends 15 ticks in C, walks once round the ring back into C, and then adds 15 more ticks. Thirty ticks in total must not fire the timeout, while 5 further ticks must. The abort-with-step and enter-with-resume collisions are driven as two-bit stimulus vectors in a single cycle. The later resume then shows at the ports which leaf history kept.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

  // Events latched for one step
  typedef struct packed {
    logic enter;
    logic resume;
    logic abort;
    logic step;
    logic a;
    logic tick;
    logic tmo;   // internally raised timeout
  } hsm_evt_t;

  // Ring successor of a leaf index
  function automatic int unsigned ring_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // Width needed to hold 0..v
  function automatic int unsigned bits_for(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/hsm_evt_latch.sv
module hsm_evt_latch
  import hsm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_enter,
  input  logic     in_resume,
  input  logic     in_abort,
  input  logic     in_step,
  input  logic     in_a,
  input  logic     in_tick,
  input  logic     in_tmo,
  output hsm_evt_t evt_q
);

  // Each event lives for exactly the step after it is raised
  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else begin
      evt_q.enter  <= in_enter;
      evt_q.resume <= in_resume;
      evt_q.abort  <= in_abort;
      evt_q.step   <= in_step;
      evt_q.a      <= in_a;
      evt_q.tick   <= in_tick;
      evt_q.tmo    <= in_tmo;
    end
  end

  // R2: a raised event never survives a second step unless raised again
  evt_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_q.step && !in_step) |=> !evt_q.step);

endmodule

// File: rtl/hsm_timer.sv
module hsm_timer
  import hsm_pkg::*;
#(
  parameter int unsigned TMO_MS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,        // timed leaf currently active
  input  logic tick,
  output logic tmo_raise
);

  localparam int unsigned CW = bits_for(TMO_MS);
  localparam logic [CW-1:0] LIMIT = CW'(TMO_MS);
  localparam logic [CW-1:0] LAST  = CW'(TMO_MS - 1);

  logic [CW-1:0] cnt_q;

  // Held at zero outside the timed leaf, so every entry restarts it
  always_ff @(posedge clk) begin
    if (rst || !run)                cnt_q <= '0;
    else if (tick && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign tmo_raise = run && tick && (cnt_q == LAST);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

  // R12
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/hsm_history.sv
module hsm_history #(
  parameter int unsigned N_SUB = 5,
  parameter int unsigned SW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          store,
  input  logic [SW-1:0] store_val,
  output logic [SW-1:0] hist_q,
  output logic          hist_valid
);

  localparam logic [SW-1:0] NONE = SW'(N_SUB);   // invalid marker

  always_ff @(posedge clk) begin
    if (rst)        hist_q <= NONE;
    else if (store) hist_q <= store_val;
  end

  assign hist_valid = (hist_q != NONE);

  // R6
  hist_load_chk: assert property (@(posedge clk) disable iff (rst)
    store |=> hist_q == $past(store_val));

  // R5: without a store the history holds still
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !store |=> $stable(hist_q));

endmodule

// File: rtl/hsm_ctrl.sv
module hsm_ctrl
  import hsm_pkg::*;
#(
  parameter int unsigned N_SUB     = 5,
  parameter int unsigned DEF_SUB   = 0,
  parameter int unsigned TIMED_SUB = 2,
  parameter int unsigned A_DEST    = 3,
  parameter int unsigned TMO_DEST  = 0,
  parameter int unsigned TMO_MS    = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_enter,
  input  logic             ev_resume,
  input  logic             ev_abort,
  input  logic             ev_step,
  input  logic             ev_a,
  input  logic             ms_tick,
  output logic [N_SUB-1:0] leaf_onehot,
  output logic             in_super
);

  localparam int unsigned SW = bits_for(N_SUB);
  localparam logic [SW-1:0] DEF_C   = SW'(DEF_SUB);
  localparam logic [SW-1:0] TIMED_C = SW'(TIMED_SUB);
  localparam logic [SW-1:0] A_C     = SW'(A_DEST);
  localparam logic [SW-1:0] TMO_C   = SW'(TMO_DEST);

  hsm_evt_t      evt;
  logic          tmo_raise;
  logic          in_s_q, in_s_d;
  logic [SW-1:0] sub_q, sub_d;
  logic [SW-1:0] hist_q;
  logic          hist_valid;
  logic          hist_store;
  logic          timed_run;

  // Named internal events for the assertions
  logic fire_abort, fire_tmo, fire_a, fire_step;

  hsm_evt_latch u_evt (
    .clk(clk), .rst(rst),
    .in_enter(ev_enter), .in_resume(ev_resume), .in_abort(ev_abort),
    .in_step(ev_step), .in_a(ev_a), .in_tick(ms_tick), .in_tmo(tmo_raise),
    .evt_q(evt)
  );

  assign timed_run = in_s_q && (sub_q == TIMED_C);

  hsm_timer #(.TMO_MS(TMO_MS)) u_tmr (
    .clk(clk), .rst(rst), .run(timed_run), .tick(evt.tick),
    .tmo_raise(tmo_raise)
  );

  hsm_history #(.N_SUB(N_SUB), .SW(SW)) u_hist (
    .clk(clk), .rst(rst), .store(hist_store), .store_val(sub_q),
    .hist_q(hist_q), .hist_valid(hist_valid)
  );

  // Priority inside the super-state: abort, timeout, a, step
  assign fire_abort = in_s_q && evt.abort;
  assign fire_tmo   = timed_run && evt.tmo && !fire_abort;
  assign fire_a     = timed_run && evt.a && !fire_abort && !fire_tmo;
  assign fire_step  = in_s_q && evt.step && !fire_abort && !fire_tmo && !fire_a;

  // Phase 2: compute every next value from current values
  always_comb begin
    in_s_d     = in_s_q;
    sub_d      = sub_q;
    hist_store = 1'b0;
    if (!in_s_q) begin
      if (evt.resume) begin
        in_s_d = 1'b1;
        sub_d  = hist_valid ? hist_q : DEF_C;
      end else if (evt.enter) begin
        in_s_d = 1'b1;
        sub_d  = DEF_C;
      end
    end else if (fire_abort) begin
      in_s_d     = 1'b0;
      hist_store = 1'b1;
    end else if (fire_tmo) begin
      sub_d = TMO_C;
    end else if (fire_a) begin
      sub_d = A_C;
    end else if (fire_step) begin
      sub_d = SW'(ring_next(int'(sub_q), N_SUB));
    end
  end

  // Phase 3: commit together
  always_ff @(posedge clk) begin
    if (rst) begin
      in_s_q <= 1'b0;
      sub_q  <= DEF_C;
    end else begin
      in_s_q <= in_s_d;
      sub_q  <= sub_d;
    end
  end

  for (genvar i = 0; i < N_SUB; i++) begin : g_leaf
    assign leaf_onehot[i] = in_s_q && (sub_q == SW'(i));
  end
  assign in_super = in_s_q;

  // R13
  onehot_leaf_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(leaf_onehot) && (in_super == (leaf_onehot != '0)));

  // R5
  abort_exit_chk: assert property (@(posedge clk) disable iff (rst)
    fire_abort |=> !in_super && hist_q == $past(sub_q));

  // R3
  default_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_s_q && evt.enter && !evt.resume) |=> in_super && leaf_onehot[DEF_SUB]);

  // R9
  resume_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_s_q && evt.resume && hist_valid) |=> in_super && sub_q == $past(hist_q));

  // R10
  a_edge_chk: assert property (@(posedge clk) disable iff (rst)
    fire_a |=> leaf_onehot[A_DEST]);

  // R11
  tmo_edge_chk: assert property (@(posedge clk) disable iff (rst)
    fire_tmo |=> leaf_onehot[TMO_DEST]);

endmodule

// File: tb/sim_hsm_ctrl.sv
`timescale 1ns/1ps
module sim_hsm_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_enter = 0, ev_resume = 0, ev_abort = 0, ev_step = 0, ev_a = 0, ms_tick = 0;
  logic [4:0] leaf_onehot;
  logic       in_super;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;   // 125 MHz

  hsm_ctrl u0 (
    .clk(clk), .rst(rst),
    .ev_enter(ev_enter), .ev_resume(ev_resume), .ev_abort(ev_abort),
    .ev_step(ev_step), .ev_a(ev_a), .ms_tick(ms_tick),
    .leaf_onehot(leaf_onehot), .in_super(in_super)
  );

  // Stimulus {enter,resume,abort,step,a,tick} , expected {in_super, leaf[4:0]}
  localparam int NV = 24;
  localparam logic [11:0] VEC [0:NV-1] = '{
    {6'b010000, 6'b100001},  // 0  R7 first resume -> A
    {6'b000100, 6'b100010},  // 1  R4 B
    {6'b000100, 6'b100100},  // 2  R4 C
    {6'b100000, 6'b100100},  // 3  R3 enter ignored inside
    {6'b000100, 6'b101000},  // 4  R4 D
    {6'b000100, 6'b110000},  // 5  R4 E
    {6'b000100, 6'b100001},  // 6  R4 wrap to A
    {6'b000100, 6'b100010},  // 7  R4 B
    {6'b001000, 6'b000000},  // 8  R5 abort from B
    {6'b110000, 6'b100010},  // 9  R9 resume beats enter -> B
    {6'b001100, 6'b000000},  // 10 R8 abort beats step
    {6'b100000, 6'b100001},  // 11 R3 default entry -> A
    {6'b000100, 6'b100010},  // 12 R4 B
    {6'b000100, 6'b100100},  // 13 R4 C
    {6'b000010, 6'b101000},  // 14 R10 a in C -> D
    {6'b001000, 6'b000000},  // 15 R5 abort from D
    {6'b010000, 6'b101000},  // 16 R6 resume -> D
    {6'b000100, 6'b110000},  // 17 R4 E
    {6'b001000, 6'b000000},  // 18 R5 abort from E
    {6'b001000, 6'b000000},  // 19 R5 abort in idle ignored
    {6'b000100, 6'b000000},  // 20 R13 step in idle ignored
    {6'b010000, 6'b110000},  // 21 R6 resume -> E, history untouched by idle abort
    {6'b000010, 6'b110000},  // 22 R10 a outside C ignored
    {6'b001000, 6'b000000}   // 23 R5 abort
  };

  task automatic chk(string req, logic [5:0] exp);
    tests++;
    if ({in_super, leaf_onehot} !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, {in_super, leaf_onehot}, exp);
    end
  endtask

  task automatic drive(logic [5:0] s);
    {ev_enter, ev_resume, ev_abort, ev_step, ev_a, ms_tick} = s;
  endtask

  // One-cycle pulse, then settle cycles
  task automatic pulse(logic [5:0] s, int settle);
    @(negedge clk); drive(s);
    @(negedge clk); drive(6'b0);
    repeat (settle) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) pulse(6'b000001, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; drive(6'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1 reset outputs", 6'b000000);

    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][11:6], 3);
      chk($sformatf("table vector %0d", i), VEC[i][5:0]);
    end

    // R1: history cleared by reset
    do_reset();
    chk("R1 reset after activity", 6'b000000);
    pulse(6'b010000, 3);
    chk("R1 resume after reset lands on A", 6'b100001);
    pulse(6'b001000, 3);

    // R2: timing and single action
    @(negedge clk); drive(6'b000100);
    @(negedge clk); drive(6'b0);
    @(negedge clk);
    chk("R2 step in idle no effect", 6'b000000);
    @(negedge clk); drive(6'b100000);
    @(negedge clk); drive(6'b0);
    chk("R2 no change after first edge", 6'b000000);
    @(negedge clk);
    chk("R2 change after second edge", 6'b100001);
    pulse(6'b000100, 4);
    chk("R2 single pulse acts once", 6'b100010);

    // R11: timeout in C
    pulse(6'b000100, 3);
    chk("R11 in C", 6'b100100);
    ticks(19);
    chk("R11 19 ticks stay in C", 6'b100100);
    ticks(1);
    chk("R11 20th tick times out to A", 6'b100001);

    // R10: a just before timeout
    pulse(6'b000100, 1);
    pulse(6'b000100, 3);
    ticks(19);
    pulse(6'b000010, 3);
    chk("R10 a after 19 ticks -> D", 6'b101000);

    // R12: restart on re-entry
    pulse(6'b000100, 1);  // E
    pulse(6'b000100, 1);  // A
    pulse(6'b000100, 1);  // B
    pulse(6'b000100, 3);  // C
    ticks(15);
    for (int k = 0; k < 5; k++) pulse(6'b000100, 1);
    repeat (2) @(negedge clk);
    chk("R12 ring back into C", 6'b100100);
    ticks(15);
    chk("R12 no carry over from prior visit", 6'b100100);
    ticks(5);
    chk("R12 fresh count of 20 times out", 6'b100001);

    // R12 via abort and resume into C
    pulse(6'b000100, 1);
    pulse(6'b000100, 3);
    ticks(12);
    pulse(6'b001000, 3);
    ticks(3);
    chk("R13 ticks in idle no effect", 6'b000000);
    pulse(6'b010000, 3);
    ticks(12);
    chk("R12 resume into C restarts count", 6'b100100);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule